// File: doc/BRIEF.md
# Multiprocessor Boot Mailbox and Semaphore Lock Slave

This slave sits on the shared system bus of a small shared-memory multiprocessor with up to `NCPU` processors. It offers two services. The first is a start-address mailbox. The boot processor, which has processor ID 0, writes a program start address into the slot of an application processor. That processor's start address output then takes the value, and its start strobe fires for one cycle to release it. The second service is a bank of `NLOCK` hardware locks. A read of a lock is an atomic test-and-set, so software can build operating-system semaphores on these locks.

Every processor has its own request channel, and the port index is the master ID. Requests use valid/ready. The slave never applies back-pressure once it is out of reset. `req_ready` is low during reset and in the first cycle after reset. From then on it stays high, and a request is taken in any cycle where valid and ready are both high. The response channel has no ready signal, so a master must take `rsp_valid`/`rsp_rdata` in the cycle they appear. All ports are served in the same cycle. When several ports reach the same lock or boot slot in one cycle, their effects are applied in ascending port order.

Top module: `smp_boot_lock`

## Requirements
- R1: While reset is held and after reset is released, every `start_addr` slot reads 0, `start_pulse` and `rsp_valid` are 0, and all locks are free.
- R2: `req_ready` is high in every cycle from the second cycle after reset onward. Every accepted request produces `rsp_valid` on the same port exactly one cycle later. A write's response carries rdata 0.
- R3: Byte address bits [1:0] are ignored. Word address w below NCPU selects boot slot w (bytes 0x00-0x1C). Word address w from NCPU up to NCPU+NLOCK-1 selects lock w-NCPU (bytes 0x20-0x5C). Reads of higher addresses return 0, and writes to them have no effect.
- R4: A write from port 0 to boot slot k≥1 stores wdata. In the cycle after acceptance, `start_addr[k]` shows the new value and `start_pulse[k]` is high for exactly that one cycle.
- R5: A boot-slot write from any port other than 0 is ignored, and so is any write to slot 0. Neither changes a start address or raises a pulse. Slot 0 always reads 0.
- R6: A read of a boot slot from any port returns the stored start address.
- R7: A lock read returns the lock's prior state in bit 0 (0 = free, 1 = held, upper bits 0) and leaves the lock held.
- R8: A lock write with wdata 0 frees the lock. A lock write with any nonzero wdata makes it held.
- R9: Accesses made in the same cycle take effect in ascending port order. Of several simultaneous reads of a free lock, only the lowest-numbered port sees 0. A boot read by port p>0 in the same cycle as a port 0 write to that slot returns the new value.
- R10: Locks are independent: accesses to different locks in the same cycle each see only their own lock's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCPU | Per-port request valid |
| req_ready | output | NCPU | Per-port request ready |
| req_write | input | NCPU | Per-port write (1) / read (0) |
| req_addr | input | NCPU*AW | Per-port byte address, port p at bits [p*AW +: AW] |
| req_wdata | input | NCPU*DW | Per-port write data |
| rsp_valid | output | NCPU | Per-port response valid, one cycle after acceptance |
| rsp_rdata | output | NCPU*DW | Per-port read data |
| start_addr | output | NCPU*DW | Start address of each processor |
| start_pulse | output | NCPU | One-cycle release strobe for each processor |

## Verification
Two functions can meet in one cycle: a test-and-set on a lock and a release of that same lock. A further case is several ports racing test-and-set reads on one free lock. The bench provokes these cases in two ways. First, directed cycles put every port on one lock, or put a release from a low port together with a read from a higher port. Second, a random phase sends all ports to a narrow range of lock addresses. A behavioural reference model applies each cycle's accesses in port order. Its expected response for every port is compared with the design's output in the following cycle. The same comparison also covers a port 0 boot write that meets a boot read of the same slot.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_BOOT = 2'd1,
    ACC_LOCK = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/sbl_port_decode.sv
module sbl_port_decode
  import sbl_pkg::*;
#(
  parameter int AW    = 8,
  parameter int NCPU  = 8,
  parameter int NLOCK = 16,
  parameter int IW    = 4
) (
  input  logic [AW-1:0] addr,
  output acc_kind_e     kind,
  output logic [IW-1:0] idx
);
  localparam int WW = AW - 2;

  logic [WW-1:0] word;
  assign word = addr[AW-1:2];

  always_comb begin
    kind = ACC_NONE;
    idx  = '0;
    if (int'(word) < NCPU) begin
      kind = ACC_BOOT;
      idx  = IW'(int'(word));
    end else if (int'(word) < NCPU + NLOCK) begin
      kind = ACC_LOCK;
      idx  = IW'(int'(word) - NCPU);
    end
  end
endmodule

// File: rtl/sbl_lock_bank.sv
module sbl_lock_bank #(
  parameter int NPORT = 8,
  parameter int NLOCK = 16,
  parameter int IW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] rd,
  input  logic [NPORT-1:0] wr,
  input  logic [NPORT-1:0] wset,
  input  logic [IW-1:0]    idx [NPORT],
  output logic [NPORT-1:0] old,
  output logic [NLOCK-1:0] held
);
  logic [NLOCK-1:0] lock_q;
  logic [NLOCK-1:0] lock_nxt;
  logic [NLOCK-1:0] touch;

  // Ports are folded in ascending order: each sees the effect of all lower ones.
  always_comb begin
    lock_nxt = lock_q;
    old      = '0;
    touch    = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (rd[p] || wr[p]) begin
        touch[idx[p]] = 1'b1;
        if (rd[p]) begin
          old[p]           = lock_nxt[idx[p]];
          lock_nxt[idx[p]] = 1'b1;
        end else begin
          lock_nxt[idx[p]] = wset[p];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lock_q <= '0;
    else        lock_q <= lock_nxt;
  end

  assign held = lock_q;

  // R9: two simultaneous readers of one lock never both find it free
  for (genvar i = 0; i < NPORT; i++) begin : g_pi
    for (genvar j = i + 1; j < NPORT; j++) begin : g_pj
      // R9
      single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr == '0 && rd[i] && rd[j] && idx[i] == idx[j] && !old[i]) |-> old[j]);
    end
  end

  for (genvar l = 0; l < NLOCK; l++) begin : g_lk
    // R7
    lock_set_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_q[l]) |-> $past(touch[l]));
  end
endmodule

// File: rtl/sbl_boot_mbox.sv
module sbl_boot_mbox #(
  parameter int NCPU = 8,
  parameter int DW   = 32,
  parameter int IW   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [DW-1:0]      wr_data,
  output logic [NCPU*DW-1:0] start_addr,
  output logic [NCPU-1:0]    start_pulse
);
  for (genvar k = 0; k < NCPU; k++) begin : g_slot
    if (k == 0) begin : g_boot_cpu
      assign start_addr[0 +: DW] = '0;
      assign start_pulse[0]      = 1'b0;
    end else begin : g_app_cpu
      logic [DW-1:0] val_q;
      logic          pl_q;
      logic          hit;
      assign hit = wr_en && (int'(wr_idx) == k);
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          val_q <= '0;
          pl_q  <= 1'b0;
        end else begin
          pl_q <= hit;
          if (hit) val_q <= wr_data;
        end
      end
      assign start_addr[k*DW +: DW] = val_q;
      assign start_pulse[k]         = pl_q;

      // R4
      pulse_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse[k] |-> $past(wr_en && int'(wr_idx) == k));
      // R5
      addr_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_addr[k*DW +: DW] != $past(start_addr[k*DW +: DW])) |-> start_pulse[k]);
    end
  end

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_pulse));
endmodule

// File: rtl/smp_boot_lock.sv
module smp_boot_lock
  import sbl_pkg::*;
#(
  parameter int NCPU  = 8,
  parameter int NLOCK = 16,
  parameter int DW    = 32,
  parameter int AW    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCPU-1:0]    req_valid,
  output logic [NCPU-1:0]    req_ready,
  input  logic [NCPU-1:0]    req_write,
  input  logic [NCPU*AW-1:0] req_addr,
  input  logic [NCPU*DW-1:0] req_wdata,
  output logic [NCPU-1:0]    rsp_valid,
  output logic [NCPU*DW-1:0] rsp_rdata,
  output logic [NCPU*DW-1:0] start_addr,
  output logic [NCPU-1:0]    start_pulse
);
  localparam int MAXN = (NCPU > NLOCK) ? NCPU : NLOCK;
  localparam int IW   = (MAXN > 1) ? $clog2(MAXN) : 1;

  logic              ready_q;
  logic [NCPU-1:0]   acc;
  acc_kind_e         kind [NCPU];
  logic [IW-1:0]     idx  [NCPU];
  logic [NCPU-1:0]   lk_rd, lk_wr, lk_wset, lk_old;
  logic [NLOCK-1:0]  lk_held;
  logic              bw_en;
  logic [NCPU-1:0]   rsp_v_q;
  logic [DW-1:0]     rsp_d_q [NCPU];
  logic [DW-1:0]     rd_mux  [NCPU];

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign req_ready = {NCPU{ready_q}};
  assign acc       = req_valid & req_ready;

  for (genvar p = 0; p < NCPU; p++) begin : g_port
    sbl_port_decode #(.AW(AW), .NCPU(NCPU), .NLOCK(NLOCK), .IW(IW)) u_dec (
      .addr (req_addr[p*AW +: AW]),
      .kind (kind[p]),
      .idx  (idx[p])
    );
    assign lk_rd[p]   = acc[p] && !req_write[p] && (kind[p] == ACC_LOCK);
    assign lk_wr[p]   = acc[p] &&  req_write[p] && (kind[p] == ACC_LOCK);
    assign lk_wset[p] = |req_wdata[p*DW +: DW];

    // Boot reads forward a same-cycle port 0 write to the same slot.
    always_comb begin
      rd_mux[p] = '0;
      if (!req_write[p]) begin
        if (kind[p] == ACC_BOOT) begin
          if (bw_en && idx[p] == idx[0]) rd_mux[p] = req_wdata[0 +: DW];
          else                           rd_mux[p] = start_addr[int'(idx[p])*DW +: DW];
        end else if (kind[p] == ACC_LOCK) begin
          rd_mux[p] = {{(DW-1){1'b0}}, lk_old[p]};
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rsp_v_q[p] <= 1'b0;
        rsp_d_q[p] <= '0;
      end else begin
        rsp_v_q[p] <= acc[p];
        rsp_d_q[p] <= acc[p] ? rd_mux[p] : '0;
      end
    end
    assign rsp_rdata[p*DW +: DW] = rsp_d_q[p];

    // R2
    ready_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_ready[p]) |-> req_ready[p]);
  end

  assign rsp_valid = rsp_v_q;
  assign bw_en = acc[0] && req_write[0] && (kind[0] == ACC_BOOT) && (idx[0] != '0);

  sbl_lock_bank #(.NPORT(NCPU), .NLOCK(NLOCK), .IW(IW)) u_locks (
    .clk   (clk),
    .rst_n (rst_n),
    .rd    (lk_rd),
    .wr    (lk_wr),
    .wset  (lk_wset),
    .idx   (idx),
    .old   (lk_old),
    .held  (lk_held)
  );

  sbl_boot_mbox #(.NCPU(NCPU), .DW(DW), .IW(IW)) u_mbox (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (bw_en),
    .wr_idx      (idx[0]),
    .wr_data     (req_wdata[0 +: DW]),
    .start_addr  (start_addr),
    .start_pulse (start_pulse)
  );

  // R8
  release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_wr[0] && !lk_wset[0] && ((lk_rd | lk_wr) == 1)) |=> !lk_held[$past(idx[0])]);
endmodule

// File: tb/smp_boot_lock_test.sv
module smp_boot_lock_test;
  localparam int NCPU = 8, NLOCK = 16, DW = 32, AW = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NCPU-1:0]    req_valid = '0, req_write = '0;
  logic [NCPU*AW-1:0] req_addr = '0;
  logic [NCPU*DW-1:0] req_wdata = '0;
  logic [NCPU-1:0]    req_ready, rsp_valid, start_pulse;
  logic [NCPU*DW-1:0] rsp_rdata, start_addr;

  smp_boot_lock #(.NCPU(NCPU), .NLOCK(NLOCK), .DW(DW), .AW(AW)) uut (.*);

  always #4 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  string cur_tag = "R1";

  // Reference model state
  logic [DW-1:0] m_boot [NCPU];
  bit            m_lock [NLOCK];
  bit [NCPU-1:0] e_rv, e_pulse;
  logic [DW-1:0] e_rd [NCPU];

  task automatic chk(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_reqs();
    req_valid = '0; req_write = '0; req_addr = '0; req_wdata = '0;
  endtask

  task automatic put(input int p, input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid[p] = 1'b1; req_write[p] = wr;
    req_addr[p*AW +: AW] = a; req_wdata[p*DW +: DW] = d;
  endtask

  task automatic model_reset();
    for (int k = 0; k < NCPU; k++) m_boot[k] = '0;
    for (int l = 0; l < NLOCK; l++) m_lock[l] = 0;
    e_rv = '0; e_pulse = '0;
    for (int k = 0; k < NCPU; k++) e_rd[k] = '0;
  endtask

  task automatic predict();
    e_pulse = '0;
    for (int p = 0; p < NCPU; p++) begin
      int w;
      e_rv[p] = req_valid[p] && req_ready[p];
      e_rd[p] = '0;
      if (!e_rv[p]) continue;
      w = int'(req_addr[p*AW +: AW]) / 4;
      if (req_write[p]) begin
        if (w < NCPU) begin
          if (p == 0 && w != 0) begin
            m_boot[w] = req_wdata[0 +: DW];
            e_pulse[w] = 1'b1;
          end
        end else if (w < NCPU + NLOCK) begin
          m_lock[w-NCPU] = (req_wdata[p*DW +: DW] != 0);
        end
      end else begin
        if (w < NCPU) e_rd[p] = m_boot[w];
        else if (w < NCPU + NLOCK) begin
          e_rd[p] = DW'(m_lock[w-NCPU]);
          m_lock[w-NCPU] = 1;
        end
      end
    end
  endtask

  task automatic compare();
    for (int p = 0; p < NCPU; p++) begin
      chk(cur_tag, $sformatf("rsp_valid[%0d]", p), DW'(rsp_valid[p]), DW'(e_rv[p]));
      if (e_rv[p]) chk(cur_tag, $sformatf("rsp_rdata[%0d]", p), rsp_rdata[p*DW +: DW], e_rd[p]);
      chk(cur_tag, $sformatf("start_addr[%0d]", p), start_addr[p*DW +: DW], m_boot[p]);
    end
    chk(cur_tag, "start_pulse", DW'(start_pulse), DW'(e_pulse));
  endtask

  // One clock: predict from the driven inputs, then compare after the edge.
  task automatic tick();
    predict();
    @(negedge clk);
    compare();
    clear_reqs();
  endtask

  function automatic logic [AW-1:0] lk(input int l);
    return AW'((NCPU + l) * 4);
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int p = 0; p < NCPU; p++) chk("R1", "start_addr in reset", start_addr[p*DW +: DW], '0);
    chk("R1", "start_pulse in reset", DW'(start_pulse), '0);
    chk("R1", "rsp_valid in reset", DW'(rsp_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cur_tag = "R2";
    chk("R2", "req_ready after reset", DW'(req_ready), DW'({NCPU{1'b1}}));
    // R1: all locks free after reset: every lock reads 0
    cur_tag = "R1";
    for (int l = 0; l < NLOCK; l++) begin
      put(l % NCPU, 0, lk(l), 0); tick();
    end
    for (int l = 0; l < NLOCK; l++) begin
      put(0, 1, lk(l), 0); tick();
    end
    // R4: port 0 writes start addresses
    cur_tag = "R4";
    for (int k = 1; k < NCPU; k++) begin
      put(0, 1, AW'(k*4), 32'h4000_0000 + 32'(k) * 32'h100); tick();
    end
    tick();
    // R5: writes from other ports and to slot 0 are ignored
    cur_tag = "R5";
    put(3, 1, 8'h08, 32'hDEAD_BEEF); tick();
    put(0, 1, 8'h00, 32'h1234_5678); tick();
    put(7, 1, 8'h1C, 32'hCAFE_0000); put(5, 1, 8'h04, 32'h1); tick();
    tick();
    // R6: boot reads from many ports
    cur_tag = "R6";
    for (int p = 0; p < NCPU; p++) put(p, 0, AW'(((p + 3) % NCPU) * 4), 0);
    tick();
    // R9: boot write by port 0 and read of same slot by port 4 in one cycle
    cur_tag = "R9";
    put(0, 1, 8'h0C, 32'h0BAD_F00D); put(4, 0, 8'h0C, 0); tick();
    tick();
    // R7: test-and-set
    cur_tag = "R7";
    put(2, 0, lk(5), 0); tick();
    put(2, 0, lk(5), 0); tick();
    // R8: release by another port, then nonzero write sets
    cur_tag = "R8";
    put(4, 1, lk(5), 0); tick();
    put(1, 0, lk(5), 0); tick();
    put(4, 1, lk(5), 0); tick();
    put(6, 1, lk(5), 32'h10); tick();
    put(1, 0, lk(5), 0); tick();
    put(1, 1, lk(5), 0); tick();
    // R9: all ports race for lock 3
    cur_tag = "R9";
    for (int p = 0; p < NCPU; p++) put(p, 0, lk(3), 0);
    tick();
    put(0, 1, lk(3), 0); tick();
    put(6, 0, lk(3), 0); put(5, 0, lk(3), 0); tick();
    // R9: release by port 1 before read by port 2 in same cycle
    put(1, 1, lk(3), 0); put(2, 0, lk(3), 0); tick();
    // R9: read by port 0 before release by port 1; lock ends free
    put(0, 0, lk(3), 0); put(1, 1, lk(3), 0); tick();
    put(7, 0, lk(3), 0); tick();
    // R10: different locks in the same cycle
    cur_tag = "R10";
    put(0, 0, lk(9), 0); tick();
    put(0, 0, lk(9), 0); put(1, 0, lk(10), 0); put(2, 1, lk(11), 1); put(3, 0, lk(12), 0); tick();
    put(4, 0, lk(11), 0); put(5, 0, lk(10), 0); put(6, 0, lk(9), 0); put(7, 0, lk(13), 0); tick();
    // R3: out-of-range and low address bits
    cur_tag = "R3";
    put(2, 1, 8'hF0, 32'hFFFF_FFFF); put(3, 0, 8'hF0, 0); put(4, 0, 8'h63, 0); tick();
    put(5, 0, 8'h83, 0); put(6, 0, 8'h07, 0); tick();
    put(5, 0, 8'h82, 0); tick();
    // Random mixed traffic concentrated on a few locks
    cur_tag = "R9";
    for (int n = 0; n < 400; n++) begin
      for (int p = 0; p < NCPU; p++) begin
        if ($urandom_range(0, 2) != 0) begin
          int sel = $urandom_range(0, 9);
          if (sel < 7) put(p, $urandom_range(0, 2) == 0, lk($urandom_range(0, 2)), $urandom_range(0, 1));
          else put(p, sel == 9, AW'($urandom_range(0, NCPU-1) * 4), $urandom);
        end
      end
      tick();
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule